// File: doc/BRIEF.md
# Write-Masked Reset Line Register Bank

This block is a small memory-mapped bank of 32-bit control words that drives a vector of peripheral reset lines. Every word owns sixteen lines. A write carries its own per-bit enable mask in its upper half. Only the lines whose enable bit is set take the new value, so software can assert or release one line with a single store and no read-modify-write. That store is atomic with respect to the other lines in the same word.

Requests arrive on a simple register port made of valid, write, address, write data and read data, with a one-cycle acknowledge. Every reset line is a flip-flop output. A read returns the present state of the sixteen lines in the addressed word. Line 0 is the whole-system restart. Software performs a restart by writing line 0 asserted and then writing it released. The block also copies line 0 to a dedicated system-reset output.

Top module: `rbk_top`

## Requirements
- R1: After reset, line n carries bit n of the parameter `RST_VAL`. Lines whose bit is 0 come up released.
- R2: A write to word k loads line bit i of that word from `acc_wdata[i]` only when `acc_wdata[16+i]` is 1. Every other bit keeps its value, and a write whose mask is all zero changes nothing.
- R3: Word k sits at byte offset 4*k, and address bits 1:0 are ignored. Line n belongs to word n/16, at bit position n mod 16.
- R4: `line_rst[n]` = 1 means line n is asserted and 0 means it is released. The lines change only on the clock edge that accepts a write.
- R5: A read of word k returns {16'b0, word k} on `acc_rdata`. The data appears in the cycle after the request, together with `acc_ready`.
- R6: `line_rst` is `NUM_REGS`*16 bits wide.
- R7: A write whose word index (address bits ADDR_W-1:2) is `NUM_REGS` or more changes no line. A read of such an index returns zero.
- R8: `sys_rst` always equals line 0, so a write that asserts line 0 followed by a write that releases it produces one restart pulse.
- R9: `acc_ready` is high in exactly the cycle after each cycle in which `acc_valid` is high, and low otherwise. The read data that goes with a write acknowledge is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address |
| acc_wdata | input | 32 | Bits 31:16 enable mask, bits 15:0 line values |
| acc_rdata | output | 32 | Read data, upper half zero |
| acc_ready | output | 1 | Access acknowledge, one cycle after the request |
| line_rst | output | NUM_REGS*16 | Reset lines, 1 = asserted |
| sys_rst | output | 1 | System restart, copy of line 0 |

## Verification
A wrong stored bit in this block shows at the reset-line outputs in the very cycle after the write that produced it, because every line is a flop output. The bench compares the whole line vector with its own model on every clock, so a wrong mask bit, a wrong word select or an out-of-range write that slipped through is caught within one cycle. Readback errors and misplaced acknowledges show on the cycle after the request, and a wrong `sys_rst` shows wherever it departs from line 0.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
  localparam int LINES_PER_WORD = 16;
  localparam int DATA_W         = 32;

  typedef logic [LINES_PER_WORD-1:0] line_word_t;

  // Apply a masked write: bit i follows data[i] only where data[16+i] is set.
  function automatic line_word_t masked_merge(line_word_t old_q, logic [DATA_W-1:0] wd);
    line_word_t en;
    line_word_t nv;
    en = wd[DATA_W-1:LINES_PER_WORD];
    nv = wd[LINES_PER_WORD-1:0];
    return (old_q & ~en) | (nv & en);
  endfunction
endpackage

// File: rtl/rbk_decode.sv
module rbk_decode #(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              in_range,
  output logic              rd_hit,
  output logic              wr_oob
);
  // Byte address to word index; the two low bits fall away.
  function automatic logic [ADDR_W-1:0] word_of(logic [ADDR_W-1:0] a);
    return a >> 2;
  endfunction

  logic [ADDR_W-1:0] word_full;

  always_comb begin
    word_full = word_of(acc_addr);
    in_range  = int'(word_full) < NUM_REGS;
    rd_idx    = word_full[IDX_W-1:0];
    rd_hit    = acc_valid && !acc_write && in_range;
    wr_oob    = acc_valid && acc_write && !in_range;
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
    assign wr_sel[k] = acc_valid && acc_write && in_range && (int'(word_full) == k);
  end
endmodule

// File: rtl/rbk_word.sv
module rbk_word
  import rbk_pkg::*;
#(
  parameter line_word_t INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output line_word_t        q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= INIT;
    else if (we) q <= masked_merge(q, wdata);
  end
endmodule

// File: rtl/rbk_rdport.sv
module rbk_rdport
  import rbk_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int NUM_LINES = NUM_REGS * LINES_PER_WORD
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic                 rd_hit,
  input  logic [IDX_W-1:0]     rd_idx,
  input  logic [NUM_LINES-1:0] lines,
  output logic [DATA_W-1:0]    rdata,
  output logic                 ready
);
  line_word_t sel_word;

  always_comb begin
    sel_word = '0;
    if (rd_hit) sel_word = lines[int'(rd_idx)*LINES_PER_WORD +: LINES_PER_WORD];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      ready <= 1'b0;
    end else begin
      rdata <= {{(DATA_W-LINES_PER_WORD){1'b0}}, sel_word};
      ready <= acc_valid;
    end
  end
endmodule

// File: rtl/rbk_top.sv
module rbk_top
  import rbk_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  parameter logic [NUM_REGS*16-1:0] RST_VAL = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic [31:0]                acc_wdata,
  output logic [31:0]                acc_rdata,
  output logic                       acc_ready,
  output logic [NUM_REGS*16-1:0]     line_rst,
  output logic                       sys_rst
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0] wr_sel;
  logic [IDX_W-1:0]    rd_idx;
  logic                in_range;
  logic                rd_hit;
  logic                wr_oob;

  rbk_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .acc_addr (acc_addr),
    .wr_sel   (wr_sel),
    .rd_idx   (rd_idx),
    .in_range (in_range),
    .rd_hit   (rd_hit),
    .wr_oob   (wr_oob)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    rbk_word #(.INIT(RST_VAL[k*LINES_PER_WORD +: LINES_PER_WORD])) u_word (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_sel[k]),
      .wdata(acc_wdata),
      .q    (line_rst[k*LINES_PER_WORD +: LINES_PER_WORD])
    );
  end

  rbk_rdport #(.NUM_REGS(NUM_REGS)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .rd_hit   (rd_hit),
    .rd_idx   (rd_idx),
    .lines    (line_rst),
    .rdata    (acc_rdata),
    .ready    (acc_ready)
  );

  assign sys_rst = line_rst[0];
endmodule

// File: rtl/rbk_checker.sv
module rbk_checker #(
  parameter int NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_valid,
  input logic                 acc_write,
  input logic                 acc_ready,
  input logic [31:0]          acc_rdata,
  input logic [NUM_LINES-1:0] lines,
  input logic                 sys_rst,
  input logic                 wr_oob
);
  // R4: lines move only after an accepted write
  p_lines_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> $stable(lines));

  // R7: out-of-range write leaves every line alone
  p_oob_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oob |=> $stable(lines));

  // R8: restart output tracks line 0
  p_sysrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst == lines[0]);

  // R9: acknowledge one cycle after each request, and only then
  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> acc_ready);
  p_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !acc_ready);

  // R5: upper half of read data is always zero
  p_rd_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> acc_rdata[31:16] == 16'h0);

  // R9: write acknowledge carries zero data
  p_wr_ack_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> acc_rdata == 32'h0);
endmodule

bind rbk_top rbk_checker #(.NUM_LINES(NUM_REGS*16)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_valid(acc_valid),
  .acc_write(acc_write),
  .acc_ready(acc_ready),
  .acc_rdata(acc_rdata),
  .lines    (line_rst),
  .sys_rst  (sys_rst),
  .wr_oob   (wr_oob)
);

// File: tb/rbk_top_test.sv
module rbk_top_test;
  localparam int NREG = 4;
  localparam int NL   = NREG * 16;
  localparam logic [NL-1:0] INITV = 64'h0003_0000_0000_0101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic acc_write = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_ready;
  logic [NL-1:0] line_rst;
  logic        sys_rst;

  int checks = 0;
  int fails  = 0;
  logic [NL-1:0] model;
  logic exp_rdy = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  rbk_top #(.NUM_REGS(NREG), .ADDR_W(8), .RST_VAL(INITV)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_ready(acc_ready), .line_rst(line_rst), .sys_rst(sys_rst)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) exp_rdy <= rst_n && acc_valid;

  // Per-cycle comparison against the behavioural model (R4, R8, R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(line_rst == model, "R4 lines", line_rst, model);
      check(sys_rst == model[0], "R8 sys_rst", sys_rst, model[0]);
      check(acc_ready == exp_rdy, "R9 ready", acc_ready, exp_rdy);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int w;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(posedge clk); #1;
    w = a / 4;
    if (w < NREG)
      for (int i = 0; i < 16; i++)
        if (d[16+i]) model[w*16+i] = d[i];
    check(acc_rdata == 32'h0, "R9 write ack data", acc_rdata, 0);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    int w;
    logic [31:0] e;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    @(posedge clk); #1;
    w = a / 4;
    e = 0;
    if (w < NREG) for (int i = 0; i < 16; i++) e[i] = model[w*16+i];
    check(acc_ready == 1'b1, {req, " ready"}, acc_ready, 1);
    check(acc_rdata == e, req, acc_rdata, e);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    model = INITV;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(line_rst == INITV, "R1 reset value", line_rst, INITV);
    check($bits(line_rst) == 64, "R6 width", $bits(line_rst), 64);
    check(acc_ready == 1'b0, "R9 idle ready", acc_ready, 0);
    rd(8'h00, "R1 R5 read word0");
    rd(8'h0C, "R1 R5 read word3");
    // R2: set one bit, leave neighbours
    wr(8'h04, 32'h0010_0010);
    check(line_rst[20] == 1'b1, "R2 single set", line_rst[20], 1);
    check(line_rst[19:16] == 4'h0, "R2 neighbours", line_rst[19:16], 0);
    // R2: zero mask changes nothing
    wr(8'h04, 32'h0000_FFFF);
    rd(8'h04, "R2 zero mask");
    // R2: mixed mask, data outside mask ignored
    wr(8'h00, 32'h00F0_0FA5);
    rd(8'h00, "R2 mixed mask");
    // R3: line 37 = word 2 bit 5, low address bits ignored
    wr(8'h0B, 32'h0020_0020);
    check(line_rst[37] == 1'b1, "R3 line 37", line_rst[37], 1);
    rd(8'h08, "R3 word2 read");
    // R4: clear a power-on asserted line
    wr(8'h0C, 32'h0002_0000);
    check(line_rst[49] == 1'b0, "R4 release", line_rst[49], 0);
    // R7: out of range
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_0000);
    rd(8'h10, "R7 oob read");
    rd(8'h0C, "R7 word3 unchanged");
    // R8: restart sequence on line 0
    wr(8'h00, 32'h0001_0001);
    check(sys_rst == 1'b1, "R8 restart asserted", sys_rst, 1);
    wr(8'h00, 32'h0001_0000);
    check(sys_rst == 1'b0, "R8 restart released", sys_rst, 0);
    // back-to-back updates across words
    for (int k = 0; k < NREG; k++) wr(8'(k*4), 32'hFFFF_0000 | 32'(16'hA5A5 ^ k));
    for (int k = 0; k < NREG; k++) rd(8'(k*4), "R2 R5 full word");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule